// File: doc/BRIEF.md
# Windowed Write-Once Watchdog Timer

This block is a watchdog timer behind a small register interface. A free-running prescaler divides the input clock by 128 to make a counting tick. A 12-bit down-counter decrements once per tick. Software must restart the counter before it passes zero. When the count passes zero, the block records a fault, raises an interrupt level and, if enabled, sends a one-cycle reset request to the system reset controller. The counter then reloads itself and keeps running.

The configuration register can be written only once after reset. That single write sets the reload value, the restart window, a disable bit, a reset-enable bit and a debug-freeze bit, and it locks the configuration until the next reset. A restart is accepted only when two conditions hold. The control write must carry the correct key byte. The counter must also have fallen to or below the window value. A keyed restart made too early is a window violation. It is recorded in the status register and is treated like a fault.

Top module: `wdt_window`

## Requirements
- R1: The counter advances once every 128 clock cycles while it runs. Two consecutive ticks are never closer than that. A reload also restarts the prescaler from zero.
- R2: After a load with reload value N, the first underflow occurs (N+1)*128 cycles later. At underflow the counter reloads N and keeps counting, so underflows repeat with that period. The count never exceeds the reload value.
- R3: Configuration (address 0) accepts only the first write after reset. Later writes leave the stored value and the counter unchanged. Field positions are: reload in bits 11:0, disable in bit 12, reset-enable in bit 13, debug-freeze in bit 14, and window in bits 27:16.
- R4: While the disable bit is set, the counter holds its value and no underflow is recorded. A keyed restart is then ignored and records no error.
- R5: When reset-enable is set, an underflow or a window violation drives `rst_req` high for one cycle, in the cycle after the event. When reset-enable is clear, `rst_req` stays low.
- R6: When debug-freeze is set, the counter and the prescaler hold while `dbg_in` is high, which delays the underflow by the frozen cycles. When debug-freeze is clear, `dbg_in` has no effect.
- R7: A write to control (address 1) with 0xA5 in bits 31:24 and bit 0 set restarts the counter from the reload value. A write with any other key, or with bit 0 clear, changes nothing.
- R8: A keyed restart while the count is above the window value does not reload the counter. It sets status bit 1 instead.
- R9: Status (address 2) holds sticky bits: bit 0 is underflow and bit 1 is window violation. Reading status returns them and clears them. `irq` is high while any status bit is set.
- R10: Reads return zero-extended values: address 0 gives the configuration and address 3 gives the current count. After reset the configuration reads 0x0FFF2FFF, which is reload 0xFFF, window 0xFFF and reset-enable set, and the count reads 0xFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the slow counting source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read clears it) |
| addr | input | 2 | Register address: 0 config, 1 control, 2 status, 3 count |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, zero when `rd_en` is low |
| dbg_in | input | 1 | Debug-halt indication from the system |
| irq | output | 1 | Fault level while any status bit is set |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The properties assume that register strobes and `dbg_in` are synchronous and stable around each rising edge. They also assume that the prescale divisor is at least two, so that ticks can be spaced. The stimulus changes inputs only on falling edges and issues one register access per cycle. It times keyed restarts and reads so that they never fall on the same edge as a prescaler tick. The exact tick counts it checks therefore follow from the requirements without any collision case.

// File: rtl/wdt_window_pkg.sv
package wdt_window_pkg;

   localparam int REG_W   = 32;
   localparam int FIELD_W = 12;
   localparam int KEY_LSB = 24;
   localparam int GO_BIT  = 0;
   localparam int ST_UF   = 0;
   localparam int ST_WIN  = 1;
   localparam int ST_W    = 2;

   typedef enum logic [1:0] {
      RA_MODE  = 2'd0,
      RA_CTRL  = 2'd1,
      RA_STAT  = 2'd2,
      RA_COUNT = 2'd3
   } reg_addr_e;

   // configuration word, most significant field first
   typedef struct packed {
      logic [3:0]         pad_hi;
      logic [FIELD_W-1:0] window;
      logic               pad_mid;
      logic               dbg_freeze;
      logic               rst_en;
      logic               halt;
      logic [FIELD_W-1:0] reload;
   } mode_t;

   localparam mode_t MODE_RESET = '{
      pad_hi:     4'h0,
      window:     {FIELD_W{1'b1}},
      pad_mid:    1'b0,
      dbg_freeze: 1'b0,
      rst_en:     1'b1,
      halt:       1'b0,
      reload:     {FIELD_W{1'b1}}
   };

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int DIV = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   localparam int  PW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit  POW2 = ((DIV & (DIV - 1)) == 0);

   logic [PW-1:0] pc_q;

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pc_q <= '0;
            else if (clr)    pc_q <= '0;
            else if (en)     pc_q <= pc_q + 1'b1;
         end
         assign tick = en && (&pc_q);
      end else begin : g_cmp
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pc_q <= '0;
            else if (clr)    pc_q <= '0;
            else if (en)     pc_q <= (pc_q == LAST) ? '0 : pc_q + 1'b1;
         end
         assign tick = en && (pc_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         run,
   input  logic         tick,
   input  logic [W-1:0] reload,
   output logic [W-1:0] cnt,
   output logic         uf
);
   logic [W-1:0] cnt_q;
   logic         at_zero;

   assign at_zero = (cnt_q == '0);
   assign uf      = run && tick && at_zero && !load;
   assign cnt     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '1;
      else if (load)          cnt_q <= reload;
      else if (run && tick)   cnt_q <= at_zero ? reload : cnt_q - 1'b1;
   end

endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
   import wdt_window_pkg::*;
#(
   parameter int          CNT_W = 12,
   parameter logic [7:0]  KEY   = 8'hA5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [1:0]       addr,
   input  logic [REG_W-1:0] wdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic             uf,
   output logic [REG_W-1:0] rdata,
   output mode_t            mode,
   output logic             locked,
   output logic             load,
   output logic [CNT_W-1:0] reload_val,
   output logic             win_err,
   output logic             irq
);
   reg_addr_e       ra;
   mode_t           mode_q;
   mode_t           mode_in;
   logic            lock_q;
   logic [ST_W-1:0] st_q;
   logic            wr_mode, go, in_win, rd_stat;

   assign ra      = reg_addr_e'(addr);
   assign mode_in = mode_t'(wdata);
   assign wr_mode = wr_en && (ra == RA_MODE) && !lock_q;
   assign go      = wr_en && (ra == RA_CTRL) && wdata[GO_BIT]
                    && (wdata[REG_W-1:KEY_LSB] == KEY) && !mode_q.halt;
   assign in_win  = FIELD_W'(cnt) <= mode_q.window;
   assign win_err = go && !in_win;
   assign load    = wr_mode || (go && in_win);
   assign rd_stat = rd_en && (ra == RA_STAT);

   assign reload_val = wr_mode ? mode_in.reload[CNT_W-1:0]
                               : mode_q.reload[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         lock_q <= 1'b0;
      end else if (wr_mode) begin
         mode_q         <= mode_in;
         mode_q.pad_hi  <= '0;
         mode_q.pad_mid <= 1'b0;
         lock_q         <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= (rd_stat ? '0 : st_q) | {win_err, uf};
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (ra)
            RA_MODE:  rdata = mode_q;
            RA_CTRL:  rdata = '0;
            RA_STAT:  rdata = REG_W'(st_q);
            RA_COUNT: rdata = REG_W'(cnt);
         endcase
      end
   end

   assign mode   = mode_q;
   assign locked = lock_q;
   assign irq    = |st_q;

endmodule

// File: rtl/wdt_window.sv
module wdt_window
   import wdt_window_pkg::*;
#(
   parameter int         CNT_W    = 12,
   parameter int         PRESCALE = 128,
   parameter logic [7:0] KEY      = 8'hA5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [1:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   input  logic        dbg_in,
   output logic        irq,
   output logic        rst_req
);
   generate
      if (CNT_W < 2 || CNT_W > FIELD_W) begin : g_bad_cnt_w
         $error("wdt_window: CNT_W must lie in 2..FIELD_W");
      end
      if (PRESCALE < 2) begin : g_bad_div
         $error("wdt_window: PRESCALE must be at least 2");
      end
   endgenerate

   mode_t            mode_q;
   logic             locked;
   logic             load, win_err, uf, tick, run;
   logic [CNT_W-1:0] cnt_q, reload_val;
   logic             rst_q;

   assign run = !mode_q.halt && !(mode_q.dbg_freeze && dbg_in);

   wdt_regfile #(.CNT_W(CNT_W), .KEY(KEY)) u_regs (
      .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata,
      .cnt(cnt_q), .uf, .rdata, .mode(mode_q), .locked,
      .load, .reload_val, .win_err, .irq
   );

   wdt_prescaler #(.DIV(PRESCALE)) u_pre (
      .clk, .rst_n, .clr(load), .en(run), .tick
   );

   wdt_downcount #(.W(CNT_W)) u_cnt (
      .clk, .rst_n, .load, .run, .tick,
      .reload(reload_val), .cnt(cnt_q), .uf
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q <= 1'b0;
      else        rst_q <= mode_q.rst_en && (uf || win_err);
   end

   assign rst_req = rst_q;

endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk
   import wdt_window_pkg::*;
#(
   parameter int         CNT_W = 12,
   parameter logic [7:0] KEY   = 8'hA5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [1:0]       addr,
   input logic [31:0]      wdata,
   input logic             dbg_in,
   input logic             irq,
   input logic             rst_req,
   input mode_t            mode,
   input logic             locked,
   input logic [CNT_W-1:0] cnt,
   input logic             tick,
   input logic             uf,
   input logic             win_err
);
   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R1
   AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= mode.reload[CNT_W-1:0]); // R2
   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      locked && wr_en && addr == RA_MODE |=> $stable(mode)); // R3
   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      locked && mode.halt |=> $stable(cnt)); // R4
   AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(mode.rst_en)); // R5
   AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      mode.dbg_freeze && dbg_in && !wr_en |=> $stable(cnt)); // R6
   AST_BAD_KEY_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == RA_CTRL && wdata[31:24] != KEY && !tick |=> $stable(cnt)); // R7
   AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == RA_STAT && !uf && !win_err |=> !irq); // R9
endmodule

bind wdt_window wdt_window_chk #(.CNT_W(CNT_W), .KEY(KEY)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .dbg_in(dbg_in), .irq(irq), .rst_req(rst_req),
   .mode(mode_q), .locked(locked), .cnt(cnt_q), .tick(tick),
   .uf(uf), .win_err(win_err)
);

// File: tb/wdt_window_test.sv
module wdt_window_test;
   localparam int DIV = 128;

   logic        clk = 1'b0;
   logic        rst_n, wr_en, rd_en, dbg_in;
   logic [1:0]  addr;
   logic [31:0] wdata, rdata;
   logic        irq, rst_req;
   int          cyc = 0;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;
   int          expq[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdt_window uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .dbg_in(dbg_in), .irq(irq), .rst_req(rst_req)
   );

   // monitor: every reset pulse must match the next scheduled cycle
   always @(negedge clk) begin
      if (rst_n === 1'b1 && rst_req === 1'b1) begin
         int e;
         n_chk++;
         if (expq.size() == 0) begin
            n_bad++;
            $display("FAIL R2/R5: reset pulse at cycle %0d, expected none", cyc);
         end else begin
            e = expq.pop_front();
            if (e != cyc) begin
               n_bad++;
               $display("FAIL R2/R5: reset pulse at cycle %0d, expected %0d", cyc, e);
            end
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drain(input string req);
      n_chk++;
      if (expq.size() != 0) begin
         n_bad++;
         $display("FAIL %s: actual %0d pulses missing expected 0", req, expq.size());
         expq.delete();
      end
   endtask

   // all tasks start at a falling edge and end at one
   task automatic do_reset();
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; dbg_in = 1'b0;
      addr = 2'd0; wdata = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d, output int e);
      wr_en = 1'b1; addr = a; wdata = d;
      e = cyc + 1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      rd_en = 1'b1; addr = a;
      #1 v = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   function automatic int exp_cnt(input int rl, input int base);
      return rl - (cyc - base) / DIV;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int e0, e1, ex;
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; dbg_in = 1'b0;
      addr = 2'd0; wdata = '0;
      @(negedge clk);

      // reset state (R10, R9)
      do_reset();
      check("R5 rst_req idle", {31'b0, rst_req}, 32'd0);
      check("R9 irq idle", {31'b0, irq}, 32'd0);
      rd(2'd0, v); check("R10 config reset", v, 32'h0FFF_2FFF);
      rd(2'd3, v); check("R10 count reset", v, 32'h0000_0FFF);
      rd(2'd2, v); check("R9 status reset", v, 32'd0);

      // period, prescale, auto-reload (R1, R2, R6 freeze off)
      wr(2'd0, 32'h0FFF_2003, e0);
      expq.push_back(e0 + 4 * DIV);
      expq.push_back(e0 + 8 * DIV);
      rd(2'd3, v); check("R10 count after load", v, 32'd3);
      wait_until(e0 + DIV - 1);
      rd(2'd3, v); check("R1 before first tick", v, 32'd3);
      rd(2'd3, v); check("R1 after first tick", v, 32'd2);
      wait_until(e0 + 200);
      dbg_in = 1'b1;
      repeat (30) @(negedge clk);
      dbg_in = 1'b0;
      wait_until(e0 + 600);
      check("R9 irq after underflow", {31'b0, irq}, 32'd1);
      rd(2'd2, v); check("R9 status underflow", v, 32'd1);
      rd(2'd2, v); check("R9 status cleared", v, 32'd0);
      check("R9 irq cleared", {31'b0, irq}, 32'd0);
      wait_until(e0 + 8 * DIV + 10);
      drain("R2 periodic underflow");
      rd(2'd3, v); check("R2 reload after underflow", v, 32'd3);

      // write-once lock (R3)
      expq.push_back(e0 + 12 * DIV);
      wr(2'd0, 32'h0000_1005, e1);
      rd(2'd0, v); check("R3 config locked", v, 32'h0FFF_2003);
      wait_until(e0 + 12 * DIV + 5);
      drain("R3 second write ignored");

      // key, window (R7, R8)
      do_reset();
      wr(2'd0, 32'h000A_2014, e0);
      wait_until(e0 + 5 * DIV + 10);
      wr(2'd1, 32'h5A00_0001, e1);
      wr(2'd1, 32'hA500_0000, e1);
      ex = exp_cnt(20, e0);
      rd(2'd3, v); check("R7 bad key or no bit ignored", v, ex);
      expq.push_back(cyc + 1);
      wr(2'd1, 32'hA500_0001, e1);
      check("R8 irq on window error", {31'b0, irq}, 32'd1);
      rd(2'd2, v); check("R8 window status", v, 32'd2);
      ex = exp_cnt(20, e0);
      rd(2'd3, v); check("R8 early restart no reload", v, ex);
      wait_until(e0 + 10 * DIV + 5);
      wr(2'd1, 32'hA500_0001, e1);
      rd(2'd3, v); check("R7 keyed restart reload", v, 32'd20);
      expq.push_back(e1 + 21 * DIV);
      wait_until(e1 + 21 * DIV + 5);
      drain("R7 timing after restart");
      rd(2'd2, v); check("R9 underflow after restart", v, 32'd1);

      // disable (R4)
      do_reset();
      wr(2'd0, 32'h0FFF_3003, e0);
      wr(2'd1, 32'hA500_0001, e1);
      rd(2'd2, v); check("R4 restart ignored when disabled", v, 32'd0);
      wait_until(e0 + 2000);
      rd(2'd3, v); check("R4 count held", v, 32'd3);
      rd(2'd2, v); check("R4 no fault", v, 32'd0);
      drain("R4 no reset pulse");

      // reset request gated (R5)
      do_reset();
      wr(2'd0, 32'h0FFF_0002, e0);
      wait_until(e0 + 3 * DIV + 5);
      check("R9 irq without reset enable", {31'b0, irq}, 32'd1);
      rd(2'd2, v); check("R5 fault recorded", v, 32'd1);
      drain("R5 no pulse when disabled");

      // debug freeze (R6)
      do_reset();
      wr(2'd0, 32'h0FFF_6003, e0);
      expq.push_back(e0 + 4 * DIV + 50);
      wait_until(e0 + 100);
      dbg_in = 1'b1;
      repeat (50) @(negedge clk);
      dbg_in = 1'b0;
      wait_until(e0 + 300);
      rd(2'd3, v); check("R6 count after freeze", v, 32'd2);
      wait_until(e0 + 4 * DIV + 55);
      drain("R6 underflow delayed");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule